// File: doc/BRIEF.md
# Secure-Zoned Backup Register File

A bank of retained 32-bit registers reached through a simple single-cycle request bus. Every request carries a secure attribute. A border configuration word holds two indices that split the bank into three zones. Indices below the lower border are private to secure masters. Indices from the lower border up to the upper border can be written only by secure masters but can be read by anyone. Indices at or above the upper border are open to every master.

A request that breaks the zone rules is refused. A refused write leaves storage unchanged. A refused read returns zero. Either one raises a one-cycle error flag. Only a secure master may change the border word, and the lower border may never exceed the upper one.

A tamper input erases every data register at once, without waiting for a clock edge. The border word is kept through a tamper event. Storage and borders are cleared only by the backup-domain reset. After that reset both borders are zero, so the whole bank is open. The block has no states beyond its stored contents, so no sequencing machine is needed.

Top module: `bkreg_zoned`

## Requirements
- R1: After the backup-domain reset, `rsp_valid`, `rsp_err` and `rsp_data` are 0, every register reads 0, and both borders are 0, so every register is open to non-secure reads and writes.
- R2: A read request (`req`=1, `wr`=0) gives `rsp_valid`=1 exactly one cycle later. A write request or an idle cycle gives `rsp_valid`=0 one cycle later.
- R3: For an index i < B1 (secure zone), a non-secure read returns 0 with `rsp_err`=1, and a non-secure write leaves the register unchanged with `rsp_err`=1.
- R4: For an index with B1 <= i < B2 (middle zone), a non-secure read returns the stored value without error, and a non-secure write is refused with `rsp_err`=1.
- R5: For an index i >= B2 (open zone), both secure and non-secure reads and writes succeed without error.
- R6: A secure access (`sec`=1) to any index from 0 to 31 succeeds without error.
- R7: The border word sits at word address 32, with B1 in bits [5:0] and B2 in bits [13:8]; all other bits read 0. It is readable by any master. A non-secure write to it is ignored and raises `rsp_err`.
- R8: A secure write to the border word whose B1 field is greater than its B2 field is refused with `rsp_err`=1, and the borders stay unchanged.
- R9: While `tamper` is high, every data register is 0. The border word is not affected by tamper.
- R10: A write in a cycle where `tamper` is sampled high is dropped, and `rsp_err` is 0 one cycle later.
- R11: Any word address above 32 is refused: a read returns 0 with `rsp_err`=1, and a write raises `rsp_err`.
- R12: `rsp_err` is high only in the cycle that follows a request. An idle cycle is followed by `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bd_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| tamper | input | 1 | Tamper wipe, active high, asynchronous |
| req | input | 1 | Request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| sec | input | 1 | 1 = secure master |
| addr | input | 6 | Word address: 0 to 31 are registers, 32 is the border word |
| wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle refusal flag |

## Verification
Every response is registered once: `rsp_valid`, `rsp_data` and `rsp_err` for a request presented before a rising edge are valid after that edge. The bench therefore drives each request just after a falling edge and samples the response at the following falling edge, half a cycle after the capturing edge. A write reaches storage at that same rising edge, so a read-back issued in the next cycle shows the new value. The tamper wipe is asynchronous, so its effect is checked with read-backs after the tamper pulse ends, and the same-cycle drop is checked through the error flag and a later read.

// File: rtl/bkz_pkg.sv
package bkz_pkg;
    typedef enum logic [1:0] {
        ZN_PRIV = 2'd0,   // secure only
        ZN_SWNR = 2'd1,   // secure write, any read
        ZN_OPEN = 2'd2    // any master
    } zone_e;

    function automatic zone_e zone_of(input logic [7:0] idx,
                                      input logic [7:0] lo,
                                      input logic [7:0] hi);
        if (idx < lo)      return ZN_PRIV;
        else if (idx < hi) return ZN_SWNR;
        else               return ZN_OPEN;
    endfunction
endpackage

// File: rtl/bkz_border.sv
module bkz_border #(
    parameter int IDX_W = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DW-1:0]    wdata,
    output logic [IDX_W-1:0] b_lo,
    output logic [IDX_W-1:0] b_hi
);
    localparam int HI_POS = 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_lo <= '0;
            b_hi <= '0;
        end else if (cfg_we) begin
            b_lo <= wdata[IDX_W-1:0];
            b_hi <= wdata[HI_POS+IDX_W-1:HI_POS];
        end
    end

    // R8: the stored borders never invert
    p_border_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        b_lo <= b_hi);
endmodule

// File: rtl/bkz_access.sv
module bkz_access
    import bkz_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = 6,
    parameter int DW    = 32
) (
    input  logic             req,
    input  logic             wr,
    input  logic             sec,
    input  logic             tamper,
    input  logic [IDX_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] b_lo,
    input  logic [IDX_W-1:0] b_hi,
    output logic             is_reg,
    output logic             reg_we,
    output logic             cfg_we,
    output logic             rd_ok,
    output logic             deny
);
    localparam int HI_POS = 8;

    zone_e            zone;
    logic             is_cfg;
    logic             wr_ok;
    logic [IDX_W-1:0] new_lo, new_hi;

    always_comb begin
        is_reg = (addr < IDX_W'(NREG));
        is_cfg = (addr == IDX_W'(NREG));
        new_lo = wdata[IDX_W-1:0];
        new_hi = wdata[HI_POS+IDX_W-1:HI_POS];
        zone   = zone_of(8'(addr), 8'(b_lo), 8'(b_hi));
        if (is_reg) begin
            wr_ok = sec || (zone == ZN_OPEN);
            rd_ok = sec || (zone != ZN_PRIV);
        end else if (is_cfg) begin
            wr_ok = sec && (new_lo <= new_hi);
            rd_ok = 1'b1;
        end else begin
            wr_ok = 1'b0;
            rd_ok = 1'b0;
        end
        reg_we = req && wr && !tamper && wr_ok && is_reg;
        cfg_we = req && wr && !tamper && wr_ok && is_cfg;
        deny   = req && (wr ? (!wr_ok && !tamper) : !rd_ok);
    end
endmodule

// File: rtl/bkz_store.sv
module bkz_store #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int LOG  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tamper,
    input  logic           we,
    input  logic [LOG-1:0] idx,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rd_val
);
    logic [DW-1:0] slot_q [NREG];
    logic          any_set;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n or posedge tamper) begin
            if (!rst_n)
                q <= '0;
            else if (tamper)
                q <= '0;
            else if (we && (idx == LOG'(g)))
                q <= wdata;
        end
        assign slot_q[g] = q;
    end

    assign rd_val = slot_q[idx];

    always_comb begin
        any_set = 1'b0;
        for (int k = 0; k < NREG; k++)
            any_set = any_set | (|slot_q[k]);
    end

    // R9: a held tamper leaves nothing stored
    p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tamper |-> !any_set);
endmodule

// File: rtl/bkreg_zoned.sv
module bkreg_zoned #(
    parameter int NREG = 32,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          bd_rst_n,
    input  logic          tamper,
    input  logic          req,
    input  logic          wr,
    input  logic          sec,
    input  logic [5:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err
);
    localparam int LOG    = $clog2(NREG);
    localparam int IDX_W  = LOG + 1;
    localparam int HI_POS = 8;

    logic [IDX_W-1:0] b_lo, b_hi;
    logic             is_reg, reg_we, cfg_we, rd_ok, deny;
    logic [DW-1:0]    reg_val, cfg_val;

    bkz_access #(.NREG(NREG), .IDX_W(IDX_W), .DW(DW)) u_acc (
        .req(req), .wr(wr), .sec(sec), .tamper(tamper),
        .addr(addr[IDX_W-1:0]), .wdata(wdata),
        .b_lo(b_lo), .b_hi(b_hi),
        .is_reg(is_reg), .reg_we(reg_we), .cfg_we(cfg_we),
        .rd_ok(rd_ok), .deny(deny)
    );

    bkz_border #(.IDX_W(IDX_W), .DW(DW)) u_brd (
        .clk(clk), .rst_n(bd_rst_n), .cfg_we(cfg_we), .wdata(wdata),
        .b_lo(b_lo), .b_hi(b_hi)
    );

    bkz_store #(.NREG(NREG), .DW(DW), .LOG(LOG)) u_st (
        .clk(clk), .rst_n(bd_rst_n), .tamper(tamper), .we(reg_we),
        .idx(addr[LOG-1:0]), .wdata(wdata), .rd_val(reg_val)
    );

    always_comb begin
        cfg_val = '0;
        cfg_val[IDX_W-1:0]               = b_lo;
        cfg_val[HI_POS+IDX_W-1:HI_POS]   = b_hi;
    end

    always_ff @(posedge clk or negedge bd_rst_n) begin
        if (!bd_rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req && !wr;
            rsp_err   <= deny;
            if (req && !wr && rd_ok)
                rsp_data <= is_reg ? reg_val : cfg_val;
            else
                rsp_data <= '0;
        end
    end

    // R2: read strobe one cycle after a read request, never otherwise
    p_rd_latency_r2: assert property (@(posedge clk) disable iff (!bd_rst_n)
        (req && !wr) |=> rsp_valid);
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!bd_rst_n)
        !(req && !wr) |=> !rsp_valid);
    // R12: error follows a request only
    p_err_after_req_r12: assert property (@(posedge clk) disable iff (!bd_rst_n)
        !req |=> !rsp_err);
    // R3: refused read carries no data
    p_denied_zero_r3: assert property (@(posedge clk) disable iff (!bd_rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));
    // R10: write under tamper is silent
    p_tamper_drop_r10: assert property (@(posedge clk) disable iff (!bd_rst_n)
        (tamper && req && wr) |=> !rsp_err);
    // R7: non-secure border write leaves borders alone
    p_cfg_ns_r7: assert property (@(posedge clk) disable iff (!bd_rst_n)
        (req && wr && !sec && addr == 6'(NREG)) |=> ($stable(b_lo) && $stable(b_hi)));
endmodule

// File: tb/sim_bkreg_zoned.sv
module sim_bkreg_zoned;
    logic        clk = 1'b0;
    logic        bd_rst_n = 1'b0;
    logic        tamper = 1'b0;
    logic        req = 1'b0, wr = 1'b0, sec = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_data;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] m_mem [32];
    int          m_lo = 0, m_hi = 0;

    always #10 clk = ~clk;

    bkreg_zoned u0 (
        .clk(clk), .bd_rst_n(bd_rst_n), .tamper(tamper), .req(req), .wr(wr),
        .sec(sec), .addr(addr), .wdata(wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int zone_f(input int i);
        if (i < m_lo) return 0;
        if (i < m_hi) return 1;
        return 2;
    endfunction

    function automatic logic [31:0] cfg_word();
        logic [31:0] v = '0;
        v[5:0]  = 6'(m_lo);
        v[13:8] = 6'(m_hi);
        return v;
    endfunction

    // drive after a falling edge; sample at the next falling edge
    task automatic acc(input string tag, input bit s, input bit w,
                       input int a, input logic [31:0] d);
        bit ok;
        logic [31:0] exp_d = '0;
        if (a < 32) begin
            ok = w ? (s || zone_f(a) == 2) : (s || zone_f(a) != 0);
            if (!w && ok) exp_d = m_mem[a];
        end else if (a == 32) begin
            ok = w ? (s && (int'(d[5:0]) <= int'(d[13:8]))) : 1'b1;
            if (!w) exp_d = cfg_word();
        end else begin
            ok = 1'b0;
        end
        req = 1'b1; wr = w; sec = s; addr = 6'(a); wdata = d;
        @(negedge clk);
        req = 1'b0;
        check({tag, " err"}, 32'(rsp_err), 32'(!ok));
        check({tag, " R2 valid"}, 32'(rsp_valid), 32'(!w));
        if (!w) check({tag, " data"}, rsp_data, exp_d);
        if (w && ok) begin
            if (a < 32) m_mem[a] = d;
            else begin m_lo = int'(d[5:0]); m_hi = int'(d[13:8]); end
        end
    endtask

    function automatic logic [31:0] bw(input int lo, input int hi);
        logic [31:0] v = '0;
        v[5:0] = 6'(lo); v[13:8] = 6'(hi);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 valid at reset", 32'(rsp_valid), 0);
        check("R1 err at reset", 32'(rsp_err), 0);
        check("R1 data at reset", rsp_data, 0);
        bd_rst_n = 1'b1;
        @(negedge clk);
        // R1: open bank after reset
        acc("R1 ns read 31", 0, 0, 31, 0);
        acc("R1 ns write 0", 0, 1, 0, 32'h1111_2222);
        acc("R1 ns read 0", 0, 0, 0, 0);
        acc("R7 cfg read", 0, 0, 32, 0);
        // R6 / R7 / R8 border programming
        acc("R6 sec cfg", 1, 1, 32, bw(4, 10));
        acc("R7 ns cfg write", 0, 1, 32, bw(0, 0));
        acc("R7 cfg readback", 0, 0, 32, 0);
        acc("R8 inverted", 1, 1, 32, bw(12, 3));
        acc("R8 cfg readback", 1, 0, 32, 0);
        // R3 secure zone
        acc("R6 sec write 2", 1, 1, 2, 32'hCAFE_0002);
        acc("R3 ns read 2", 0, 0, 2, 0);
        acc("R3 ns write 2", 0, 1, 2, 32'hBAD0_BAD0);
        acc("R3 sec readback 2", 1, 0, 2, 0);
        acc("R3 ns read 0", 0, 0, 0, 0);
        // R4 middle zone
        acc("R6 sec write 7", 1, 1, 7, 32'h7777_0007);
        acc("R4 ns read 7", 0, 0, 7, 0);
        acc("R4 ns write 7", 0, 1, 7, 32'h0);
        acc("R4 ns readback 7", 0, 0, 7, 0);
        acc("R4 edge 4", 0, 0, 4, 0);
        acc("R4 edge 9 write", 0, 1, 9, 32'h9);
        // R5 open zone
        acc("R5 ns write 10", 0, 1, 10, 32'hA0A0_0010);
        acc("R5 sec read 10", 1, 0, 10, 0);
        acc("R5 sec write 31", 1, 1, 31, 32'h3131_3131);
        acc("R5 ns read 31", 0, 0, 31, 0);
        // R11 out of range
        acc("R11 read 40", 1, 0, 40, 0);
        acc("R11 write 63", 1, 1, 63, 32'hFFFF_FFFF);
        // R12 idle after a refusal
        @(negedge clk);
        check("R12 idle err", 32'(rsp_err), 0);
        check("R2 idle valid", 32'(rsp_valid), 0);
        // random traffic
        for (int n = 0; n < 600; n++) begin
            int a;
            bit s, w;
            logic [31:0] d;
            s = 1'($urandom);
            w = 1'($urandom);
            a = ($urandom % 10 == 0) ? 32 + int'($urandom % 32) : int'($urandom % 32);
            d = $urandom;
            if (a == 32) d = bw(int'($urandom % 34), int'($urandom % 34));
            acc("R3/R4/R5/R6 random", s, w, a, d);
        end
        // R9 tamper wipe, borders kept
        acc("R9 pre cfg", 1, 1, 32, bw(5, 20));
        for (int i = 0; i < 32; i++) acc("R9 fill", 1, 1, i, 32'h100 + 32'(i));
        #5 tamper = 1'b1;
        @(negedge clk);
        #5 tamper = 1'b0;
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        @(negedge clk);
        for (int i = 0; i < 32; i++) acc("R9 wiped", 1, 0, i, 0);
        acc("R9 cfg kept", 0, 0, 32, 0);
        check("R9 cfg value", {18'b0, 6'(m_hi), 2'b0, 6'(m_lo)}, bw(5, 20));
        // R10 tamper with a write in the same cycle
        tamper = 1'b1;
        req = 1'b1; wr = 1'b1; sec = 1'b1; addr = 6'd25; wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req = 1'b0;
        check("R10 no err", 32'(rsp_err), 0);
        tamper = 1'b0;
        @(negedge clk);
        acc("R10 dropped", 1, 0, 25, 0);
        tamper = 1'b1;
        req = 1'b1; wr = 1'b1; sec = 1'b1; addr = 6'd32; wdata = bw(1, 2);
        @(negedge clk);
        req = 1'b0;
        tamper = 1'b0;
        check("R10 cfg no err", 32'(rsp_err), 0);
        acc("R10 cfg unchanged", 1, 0, 32, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule